// File: doc/BRIEF.md
# Address-Monitor Wait Sleep Controller

This block is the core-side control for a two-step sleep sequence. A monitor request records a cache-line-aligned address and arms it. A later wait request puts the core into a low-power wait state, but only if that arm is still valid. The block then watches the store-snoop bus and a set of event lines: maskable interrupt, NMI, SMI, debug, machine check, bus-init, INIT and hard reset. It also runs a programmable timeout. The first qualifying cause ends the sleep, and the block reports which resume action the core must take.

Before any sleep decision, the wait request is screened. If the feature is turned off by its control input, the block raises an illegal-opcode fault. A nonzero extension operand raises a general-protection fault. The hint operand is never checked. Its low bits are passed on as the requested sleep depth, and its upper bits are discarded. The block does no privilege check, so the wait behaves the same at every privilege level.

All outputs are registered. A decision appears on the outputs one clock after the request or event that caused it.

Top module: `mw_sleep_ctl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `armed`, `asleep`, `done`, `flt_gp` and `flt_ud` are 0.
- R2: A `mon_req` made while not asleep arms the block on the next cycle when `mon_ok`=1, and leaves it disarmed when `mon_ok`=0. A `wt_req` made while disarmed gives `done`=1 with `done_code`=0 (resume at the next instruction) on the next cycle, and `asleep` stays 0.
- R3: A `wt_req` made while armed, with `wt_ext`=0 and `feat_off`=0, raises `asleep` on the next cycle. `sleep_hint` then holds the low HINT_W bits of `wt_hint`. The upper bits of `wt_hint` have no effect.
- R4: A snoop store is a hit when its address with the low LINE_B bits cleared (a 64-byte line by default) equals the armed base. A hit while asleep ends the sleep with `done_code`=0. A store to another line does not wake the block.
- R5: `ev_irq` ends the sleep with `done_code`=1 only if `ie` was 1 on the cycle the wait request was accepted. Otherwise it is ignored. `ev_nmi` always ends the sleep with `done_code`=1.
- R6: `ev_smi` ends the sleep with `done_code`=2 (handle SMI, then resume at the next instruction).
- R7: These events end the sleep unconditionally: `ev_dbg` gives code 3, `ev_mce` gives code 4, and `ev_binit`, `ev_init` or `ev_rst` give code 5.
- R8: When several causes are present in the same cycle, the code follows this priority: 5, then 4, then 3, then 2, then 1, then store hit or timeout (0).
- R9: Every wake drops `asleep` and clears `armed` on the same cycle that `done` pulses for one cycle. Event lines have no effect while the block is not asleep.
- R10: With `tmo_limit`=L and L nonzero, `asleep` stays high for exactly L+1 cycles and then `done`=1 with code 0. With L=0 there is no timeout.
- R11: A `wt_req` with nonzero `wt_ext` and `feat_off`=0 gives `flt_gp`=1 on the next cycle, with no sleep and no `done`.
- R12: `feat_flag` is the inverse of `feat_off`, delayed by one cycle. A `wt_req` made with `feat_off`=1 gives `flt_ud`=1 instead of sleeping. This fault takes precedence over the `flt_gp` fault.
- R13: A store hit while armed and not asleep clears `armed`, so a following wait completes at once with code 0. A store to another line keeps the arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_req | input | 1 | Monitor (arm) request |
| mon_ok | input | 1 | The arm request succeeded |
| mon_addr | input | AW | Address to arm |
| wt_req | input | 1 | Wait request |
| wt_hint | input | DW | Hint operand (requested sleep depth) |
| wt_ext | input | DW | Extension operand; any nonzero value is reserved |
| ie | input | 1 | Current interrupt-enable state |
| feat_off | input | 1 | Feature disable control |
| tmo_limit | input | TW | Sleep timeout in cycles; 0 means no timeout |
| snp_vld | input | 1 | Snooped store valid |
| snp_addr | input | AW | Snooped store address |
| ev_irq | input | 1 | Maskable interrupt pending |
| ev_nmi | input | 1 | NMI |
| ev_smi | input | 1 | SMI |
| ev_dbg | input | 1 | Debug exception |
| ev_mce | input | 1 | Machine check |
| ev_binit | input | 1 | Bus-init event |
| ev_init | input | 1 | INIT event |
| ev_rst | input | 1 | Hard reset event |
| armed | output | 1 | An address line is armed |
| asleep | output | 1 | In the wait state |
| sleep_hint | output | HINT_W | Requested sleep depth captured at entry |
| done | output | 1 | One-cycle pulse: the wait has finished |
| done_code | output | 3 | Resume action: 0 next instruction, 1 service interrupt, 2 SMI then next, 3 debug, 4 machine check, 5 init/reset |
| flt_gp | output | 1 | General-protection fault pulse |
| flt_ud | output | 1 | Illegal-opcode fault pulse |
| feat_flag | output | 1 | Feature-present flag |

## Verification
A table of arm-then-wait scenarios is driven through the wake logic:
- Single wake causes separate the resume codes.
- Interrupt cases, with interrupts enabled and disabled at entry, separate the conditional interrupt path from the unconditional NMI path.
- Stores to the armed line and to the next line separate the line-granular compare from an exact-address compare.
- Mixed causes in one cycle expose the priority order.
- Failed arms, nonzero extension operands and the disable control separate the three ways a request can finish without sleeping.

Directed cases then check timeout length, disarm by a store before the wait, events while idle, and reset during sleep.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    RES_NEXT = 3'd0,
    RES_INTR = 3'd1,
    RES_SMI  = 3'd2,
    RES_DBG  = 3'd3,
    RES_MCE  = 3'd4,
    RES_INIT = 3'd5
  } res_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SLEEP = 1'b1
  } st_e;

  // event vector bit positions fed to the wake arbiter
  localparam int EV_IRQ   = 0;
  localparam int EV_NMI   = 1;
  localparam int EV_SMI   = 2;
  localparam int EV_DBG   = 3;
  localparam int EV_MCE   = 4;
  localparam int EV_BINIT = 5;
  localparam int EV_INIT  = 6;
  localparam int EV_RST   = 7;
  localparam int EV_N     = 8;
endpackage

// File: rtl/mw_arm.sv
module mw_arm #(
  parameter int AW     = 32,
  parameter int LINE_B = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_req,
  input  logic          set_ok,
  input  logic [AW-1:0] set_addr,
  input  logic          clr,
  input  logic          snp_vld,
  input  logic [AW-1:0] snp_addr,
  output logic          armed,
  output logic          hit
);
  localparam logic [AW-1:0] LMASK = {{(AW-LINE_B){1'b1}}, {LINE_B{1'b0}}};

  logic [AW-1:0] base_q;

  // a new arm request wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      armed  <= 1'b0;
      base_q <= '0;
    end else if (set_req) begin
      armed  <= set_ok;
      base_q <= set_addr & LMASK;
    end else if (clr) begin
      armed  <= 1'b0;
    end
  end

  assign hit = armed && snp_vld && ((snp_addr & LMASK) == base_q);
endmodule

// File: rtl/mw_screen.sv
module mw_screen #(
  parameter int DW = 32
) (
  input  logic          feat_off,
  input  logic [DW-1:0] ext,
  output logic          ud,
  output logic          gp
);
  // the disabled-feature fault masks the operand check
  assign ud = feat_off;
  assign gp = !feat_off && (|ext);
endmodule

// File: rtl/mw_tmo.sv
module mw_tmo #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          expire
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt != {TW{1'b1}}) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expire = run && (limit != '0) && (cnt == limit);
endmodule

// File: rtl/mw_wake.sv
module mw_wake
  import mw_pkg::*;
(
  input  logic [EV_N-1:0] ev,
  input  logic            ie_lat,
  input  logic            hit,
  input  logic            tmo,
  output logic            wake,
  output res_e            code
);
  always_comb begin
    wake = 1'b1;
    code = RES_NEXT;
    if (ev[EV_RST] || ev[EV_INIT] || ev[EV_BINIT]) begin
      code = RES_INIT;
    end else if (ev[EV_MCE]) begin
      code = RES_MCE;
    end else if (ev[EV_DBG]) begin
      code = RES_DBG;
    end else if (ev[EV_SMI]) begin
      code = RES_SMI;
    end else if (ev[EV_NMI] || (ev[EV_IRQ] && ie_lat)) begin
      code = RES_INTR;
    end else if (hit || tmo) begin
      code = RES_NEXT;
    end else begin
      wake = 1'b0;
    end
  end
endmodule

// File: rtl/mw_sleep_ctl.sv
module mw_sleep_ctl
  import mw_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int HINT_W = 8,
  parameter int LINE_B = 6,
  parameter int TW     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mon_req,
  input  logic              mon_ok,
  input  logic [AW-1:0]     mon_addr,
  input  logic              wt_req,
  input  logic [DW-1:0]     wt_hint,
  input  logic [DW-1:0]     wt_ext,
  input  logic              ie,
  input  logic              feat_off,
  input  logic [TW-1:0]     tmo_limit,
  input  logic              snp_vld,
  input  logic [AW-1:0]     snp_addr,
  input  logic              ev_irq,
  input  logic              ev_nmi,
  input  logic              ev_smi,
  input  logic              ev_dbg,
  input  logic              ev_mce,
  input  logic              ev_binit,
  input  logic              ev_init,
  input  logic              ev_rst,
  output logic              armed,
  output logic              asleep,
  output logic [HINT_W-1:0] sleep_hint,
  output logic              done,
  output logic [2:0]        done_code,
  output logic              flt_gp,
  output logic              flt_ud,
  output logic              feat_flag
);
  st_e             st;
  logic            ie_lat;
  logic            idle;
  logic            hit;
  logic            wake;
  res_e            wcode;
  logic            tmo;
  logic            f_ud;
  logic            f_gp;
  logic [EV_N-1:0] ev;
  logic            unused_hint_hi;

  assign idle   = (st == ST_IDLE);
  assign asleep = (st == ST_SLEEP);

  assign ev[EV_IRQ]   = ev_irq;
  assign ev[EV_NMI]   = ev_nmi;
  assign ev[EV_SMI]   = ev_smi;
  assign ev[EV_DBG]   = ev_dbg;
  assign ev[EV_MCE]   = ev_mce;
  assign ev[EV_BINIT] = ev_binit;
  assign ev[EV_INIT]  = ev_init;
  assign ev[EV_RST]   = ev_rst;

  // hint bits above the depth field are reserved and discarded
  assign unused_hint_hi = ^wt_hint[DW-1:HINT_W];

  mw_arm #(.AW(AW), .LINE_B(LINE_B)) u_arm (
    .clk      (clk),
    .rst      (rst),
    .set_req  (mon_req && idle),
    .set_ok   (mon_ok),
    .set_addr (mon_addr),
    .clr      ((asleep && wake) || (idle && hit)),
    .snp_vld  (snp_vld),
    .snp_addr (snp_addr),
    .armed    (armed),
    .hit      (hit)
  );

  mw_screen #(.DW(DW)) u_scr (
    .feat_off (feat_off),
    .ext      (wt_ext),
    .ud       (f_ud),
    .gp       (f_gp)
  );

  mw_tmo #(.TW(TW)) u_tmo (
    .clk    (clk),
    .rst    (rst),
    .run    (asleep),
    .limit  (tmo_limit),
    .expire (tmo)
  );

  mw_wake u_wake (
    .ev     (ev),
    .ie_lat (ie_lat),
    .hit    (hit),
    .tmo    (tmo),
    .wake   (wake),
    .code   (wcode)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      ie_lat     <= 1'b0;
      sleep_hint <= '0;
      done       <= 1'b0;
      done_code  <= RES_NEXT;
      flt_gp     <= 1'b0;
      flt_ud     <= 1'b0;
      feat_flag  <= 1'b0;
    end else begin
      done      <= 1'b0;
      flt_gp    <= 1'b0;
      flt_ud    <= 1'b0;
      feat_flag <= !feat_off;
      unique case (st)
        ST_IDLE: begin
          if (wt_req) begin
            if (f_ud) begin
              flt_ud <= 1'b1;
            end else if (f_gp) begin
              flt_gp <= 1'b1;
            end else if (armed && !hit) begin
              st         <= ST_SLEEP;
              ie_lat     <= ie;
              sleep_hint <= wt_hint[HINT_W-1:0];
            end else begin
              done      <= 1'b1;
              done_code <= RES_NEXT;
            end
          end
        end
        ST_SLEEP: begin
          if (wake) begin
            st        <= ST_IDLE;
            done      <= 1'b1;
            done_code <= wcode;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mw_sleep_ctl_chk.sv
module mw_sleep_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       ev_irq,
  input logic       ev_nmi,
  input logic       ev_smi,
  input logic       ev_dbg,
  input logic       ev_mce,
  input logic       ev_binit,
  input logic       ev_init,
  input logic       ev_rst,
  input logic       armed,
  input logic       asleep,
  input logic       done,
  input logic [2:0] done_code,
  input logic       flt_gp,
  input logic       flt_ud,
  input logic       feat_flag
);
  // R2
  enter_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(asleep) |-> $past(armed));

  // R9
  done_awake_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !asleep);

  // R9
  wake_disarm_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(asleep) |-> (done && !armed));

  // R12
  ud_excl_chk: assert property (@(posedge clk) disable iff (rst)
    flt_ud |-> (!feat_flag && !flt_gp && !asleep && !done));

  // R11
  gp_nosleep_chk: assert property (@(posedge clk) disable iff (rst)
    flt_gp |-> (!asleep && !done));

  // R7
  hard_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (asleep && (ev_rst || ev_init || ev_binit)) |=> (done && done_code == 3'd5 && !asleep));

  // R6
  smi_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (asleep && ev_smi && !(ev_mce || ev_dbg || ev_binit || ev_init || ev_rst))
      |=> (done && done_code == 3'd2));

  // R5
  intr_src_chk: assert property (@(posedge clk) disable iff (rst)
    (done && done_code == 3'd1) |-> $past(ev_irq || ev_nmi));
endmodule

bind mw_sleep_ctl mw_sleep_ctl_chk u_chk (.*);

// File: tb/mw_sleep_ctl_test.sv
module mw_sleep_ctl_test;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int HW = 8;
  localparam int TW = 16;
  localparam logic [AW-1:0] BASE = 32'h0000_4A40;

  localparam logic [9:0] E_IRQ = 10'h001, E_NMI = 10'h002, E_SMI = 10'h004,
                         E_DBG = 10'h008, E_MCE = 10'h010, E_BIN = 10'h020,
                         E_INI = 10'h040, E_RST = 10'h080, E_HIT = 10'h100,
                         E_MIS = 10'h200;
  localparam logic [2:0] K_NOW = 3'd0, K_GP = 3'd1, K_UD = 3'd2,
                         K_WAKE = 3'd3, K_STAY = 3'd4;

  typedef struct packed {
    logic          arm;
    logic          ok;
    logic [DW-1:0] ext;
    logic          ie;
    logic          off;
    logic [9:0]    ev;
    logic [2:0]    kind;
    logic [2:0]    code;
    logic [3:0]    rq;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VT [NV] = '{
    '{1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 10'h000, K_NOW,  3'd0, 4'd2},  // R2 failed arm
    '{1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 10'h000, K_NOW,  3'd0, 4'd2},  // R2 never armed
    '{1'b1, 1'b1, 32'h0, 1'b0, 1'b0, E_HIT,   K_WAKE, 3'd0, 4'd4},  // R4
    '{1'b1, 1'b1, 32'h0, 1'b1, 1'b0, E_IRQ,   K_WAKE, 3'd1, 4'd5},  // R5
    '{1'b1, 1'b1, 32'h0, 1'b0, 1'b0, E_IRQ,   K_STAY, 3'd0, 4'd5},  // R5 masked
    '{1'b1, 1'b1, 32'h0, 1'b0, 1'b0, E_NMI,   K_WAKE, 3'd1, 4'd5},  // R5 nmi
    '{1'b1, 1'b1, 32'h0, 1'b0, 1'b0, E_SMI,   K_WAKE, 3'd2, 4'd6},  // R6
    '{1'b1, 1'b1, 32'h0, 1'b0, 1'b0, E_DBG,   K_WAKE, 3'd3, 4'd7},  // R7
    '{1'b1, 1'b1, 32'h0, 1'b0, 1'b0, E_MCE,   K_WAKE, 3'd4, 4'd7},
    '{1'b1, 1'b1, 32'h0, 1'b0, 1'b0, E_BIN,   K_WAKE, 3'd5, 4'd7},
    '{1'b1, 1'b1, 32'h0, 1'b0, 1'b0, E_INI,   K_WAKE, 3'd5, 4'd7},
    '{1'b1, 1'b1, 32'h0, 1'b0, 1'b0, E_RST,   K_WAKE, 3'd5, 4'd7},
    '{1'b1, 1'b1, 32'h0, 1'b1, 1'b0, E_MIS,   K_STAY, 3'd0, 4'd4},  // R4 other line
    '{1'b1, 1'b1, 32'h0, 1'b1, 1'b0, E_IRQ | E_SMI | E_HIT, K_WAKE, 3'd2, 4'd8}, // R8
    '{1'b1, 1'b1, 32'h0, 1'b0, 1'b0, E_MCE | E_RST,         K_WAKE, 3'd5, 4'd8},
    '{1'b1, 1'b1, 32'h0, 1'b1, 1'b0, E_IRQ | E_HIT,         K_WAKE, 3'd1, 4'd8},
    '{1'b1, 1'b1, 32'h0, 1'b0, 1'b0, E_DBG | E_SMI | E_NMI, K_WAKE, 3'd3, 4'd8},
    '{1'b1, 1'b1, 32'h1, 1'b0, 1'b0, 10'h000, K_GP,   3'd0, 4'd11}, // R11
    '{1'b1, 1'b1, 32'h8000_0000, 1'b0, 1'b1, 10'h000, K_UD, 3'd0, 4'd12}, // R12
    '{1'b1, 1'b1, 32'h0, 1'b1, 1'b0, E_HIT,   K_WAKE, 3'd0, 4'd3}   // R3 hint
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          mon_req, mon_ok, wt_req, ie, feat_off, snp_vld;
  logic [AW-1:0] mon_addr, snp_addr;
  logic [DW-1:0] wt_hint, wt_ext;
  logic [TW-1:0] tmo_limit;
  logic          ev_irq, ev_nmi, ev_smi, ev_dbg, ev_mce, ev_binit, ev_init, ev_rst;
  logic          armed, asleep, done, flt_gp, flt_ud, feat_flag;
  logic [HW-1:0] sleep_hint;
  logic [2:0]    done_code;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  mw_sleep_ctl uut (
    .clk(clk), .rst(rst), .mon_req(mon_req), .mon_ok(mon_ok), .mon_addr(mon_addr),
    .wt_req(wt_req), .wt_hint(wt_hint), .wt_ext(wt_ext), .ie(ie), .feat_off(feat_off),
    .tmo_limit(tmo_limit), .snp_vld(snp_vld), .snp_addr(snp_addr),
    .ev_irq(ev_irq), .ev_nmi(ev_nmi), .ev_smi(ev_smi), .ev_dbg(ev_dbg), .ev_mce(ev_mce),
    .ev_binit(ev_binit), .ev_init(ev_init), .ev_rst(ev_rst),
    .armed(armed), .asleep(asleep), .sleep_hint(sleep_hint), .done(done),
    .done_code(done_code), .flt_gp(flt_gp), .flt_ud(flt_ud), .feat_flag(feat_flag)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic drive_ev(input logic [9:0] e);
    ev_irq   = e[0]; ev_nmi  = e[1]; ev_smi  = e[2]; ev_dbg = e[3];
    ev_mce   = e[4]; ev_binit = e[5]; ev_init = e[6]; ev_rst = e[7];
    snp_vld  = e[8] | e[9];
    snp_addr = e[8] ? BASE + 32'h3F : BASE + 32'h40;
  endtask

  task automatic arm_line();
    @(negedge clk); mon_req = 1'b1; mon_ok = 1'b1; mon_addr = BASE + 32'h11;
    @(negedge clk); mon_req = 1'b0;
  endtask

  task automatic enter_wait(input logic ie_v);
    wt_req = 1'b1; wt_ext = '0; ie = ie_v;
    @(negedge clk); wt_req = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; mon_req = 1'b0; mon_ok = 1'b0; mon_addr = '0; wt_req = 1'b0;
    wt_hint = 32'hFFFF_FFA5; wt_ext = '0; ie = 1'b0; feat_off = 1'b0; tmo_limit = '0;
    drive_ev(10'h000);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!armed && !asleep && !done && !flt_gp && !flt_ud, "R1", {armed, asleep, done, flt_gp, flt_ud}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!armed && !asleep && !done && !flt_gp && !flt_ud, "R1", {armed, asleep, done, flt_gp, flt_ud}, 0);
    chk(feat_flag, "R12", feat_flag, 1);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string rq;
      v  = VT[i];
      rq = $sformatf("R%0d", v.rq);
      @(negedge clk);
      chk(!done, "R9", done, 0);
      mon_req = v.arm; mon_ok = v.ok; mon_addr = BASE + 32'h11;
      @(negedge clk);
      mon_req = 1'b0;
      chk(armed == (v.arm & v.ok), "R2", armed, v.arm & v.ok);
      wt_req = 1'b1; wt_ext = v.ext; ie = v.ie; feat_off = v.off;
      @(negedge clk);
      wt_req = 1'b0;
      case (v.kind)
        K_NOW:  chk(done && done_code == 3'd0 && !asleep, rq, {done, asleep, done_code}, 3'b100);
        K_GP:   chk(flt_gp && !flt_ud && !asleep && !done, rq, {flt_gp, flt_ud, asleep, done}, 4'b1000);
        K_UD:   chk(flt_ud && !flt_gp && !feat_flag && !asleep, rq, {flt_ud, flt_gp, feat_flag, asleep}, 4'b1000);
        default: begin
          chk(asleep && !done, rq, {asleep, done}, 2'b10);
          chk(sleep_hint == 8'hA5, "R3", sleep_hint, 8'hA5);
        end
      endcase
      drive_ev(v.ev);
      @(negedge clk);
      drive_ev(10'h000); feat_off = 1'b0;
      if (v.kind == K_WAKE) begin
        chk(done && done_code == v.code && !asleep && !armed, rq,
            {done, asleep, armed, done_code}, {3'b100, v.code});
      end else if (v.kind == K_STAY) begin
        chk(asleep && !done, rq, {asleep, done}, 2'b10);
        ev_dbg = 1'b1;
        @(negedge clk);
        ev_dbg = 1'b0;
        chk(done && done_code == 3'd3 && !armed, "R7", {done, armed, done_code}, 5'b10011);
      end
    end

    // R10 timeout of 4 keeps asleep for 5 cycles
    begin
      int n;
      tmo_limit = 16'd4;
      arm_line();
      enter_wait(1'b0);
      n = 0;
      while (asleep && n < 20) begin
        n++;
        @(negedge clk);
      end
      chk(n == 5, "R10", n, 5);
      chk(done && done_code == 3'd0, "R10", {done, done_code}, 4'b1000);
      tmo_limit = '0;
    end

    // R10 zero limit never times out
    arm_line();
    enter_wait(1'b0);
    repeat (40) @(negedge clk);
    chk(asleep && !done, "R10", {asleep, done}, 2'b10);
    ev_rst = 1'b1;
    @(negedge clk);
    ev_rst = 1'b0;
    chk(done && done_code == 3'd5, "R7", {done, done_code}, 4'b1101);

    // R13 store to another line keeps the arm, a hit drops it
    arm_line();
    drive_ev(E_MIS);
    @(negedge clk);
    drive_ev(10'h000);
    chk(armed, "R13", armed, 1);
    drive_ev(E_HIT);
    @(negedge clk);
    drive_ev(10'h000);
    chk(!armed, "R13", armed, 0);
    enter_wait(1'b1);
    chk(done && done_code == 3'd0 && !asleep, "R13", {done, asleep, done_code}, 5'b10000);

    // R9 events while idle do nothing
    @(negedge clk);
    drive_ev(10'h0FF);
    @(negedge clk);
    drive_ev(10'h000);
    chk(!done && !asleep, "R9", {done, asleep}, 0);

    // R1 reset during sleep
    arm_line();
    enter_wait(1'b1);
    chk(asleep, "R3", asleep, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!asleep && !armed && !done, "R1", {asleep, armed, done}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule